// File: doc/BRIEF.md
# Shared-Register Expected-Value Monitor

This block is a run-time checker placed beside one datapath register that several logical operations write in turn. Each operation owns an ordered list of expected values, computed when the design is elaborated. Whenever an operation's strobe fires, the monitor takes the relevant slice of the register and compares it with the entry that this operation's own position counter selects. The counter then moves on. Because every operation has a private counter, their sequences may interleave in time in any order.

Each operation has a criticality setting that grades a mismatch. A non-critical mismatch, such as a speculative write that is later redone, raises a one-cycle warning. A critical mismatch halts. Other faults also halt: an operation that fires past the end of its list, or two operations that claim the register in the same cycle. The halt is sticky until reset. The details of the first fault are frozen for inspection: its kind, the operation, the execution index, the expected and actual values, and the cycle.

The checker is a three-state machine:
- `ST_RUN`: no fault seen so far.
- `ST_WARNED`: at least one warning, and the fault record is frozen.
- `ST_HALTED`: terminal until reset.

Its transitions are:
- `ST_RUN` to `ST_WARNED` on a non-critical mismatch.
- `ST_RUN` to `ST_HALTED` on any critical-class fault.
- `ST_WARNED` to `ST_HALTED` on any critical-class fault.
- `ST_HALTED` stays in `ST_HALTED`.

Top module: `trace_checker`

## Requirements
- R1: After reset, `mismatch_o`, `warn_o` and `halt_o` are 0, and every fault-record output (`flt_code`, `flt_op`, `flt_count`, `flt_expected`, `flt_actual`, `flt_cycle`) is 0.
- R2: Only bits [CMP_LSB+CMP_W-1:CMP_LSB] of `reg_val` take part in the comparison, shifted down to bit 0. With the defaults these are bits [11:4], and the other bits never change the outcome.
- R3: Entry i of operation k's list is ((k+1)*16 + 3*i + 1) mod 2^CMP_W. Operation k has DEPTH - (k mod DEPTH) entries, which gives 4, 3 and 2 entries with the defaults. Execution n of an operation (counting from 0) is compared with its entry n.
- R4: Each operation keeps its own position. Strobes of different operations may interleave in any order without shifting one another's expected sequence.
- R5: When exactly one strobe fires and the monitor is not halted, that operation's position advances by one whether or not the values matched. It saturates at the list length.
- R6: A value mismatch on an operation whose `op_critical` bit is 0 pulses `mismatch_o` and `warn_o` for one cycle and leaves `halt_o` at 0. All outputs respond in the cycle after the strobe is sampled.
- R7: A value mismatch on an operation whose `op_critical` bit is 1 pulses `mismatch_o` and sets `halt_o`. `halt_o` then stays 1 until reset.
- R8: A strobe on an operation whose position equals its list length is an overrun. An overrun is critical regardless of `op_critical`. It records fault code 3, with an expected value of 0 and the count equal to the list length.
- R9: Two or more strobes in one cycle are a conflict. A conflict is critical. It records fault code 4 and the lowest active operation index, and no position advances.
- R10: The first fault of any kind is recorded. Fault codes are: 1 for a warning, 2 for a critical mismatch, 3 for an overrun and 4 for a conflict. The recorded cycle is the number of clock edges since reset release at which the strobe was sampled, counting the first such edge as 0. Later faults never overwrite the record.
- R11: While halted, strobes produce no `mismatch_o` or `warn_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_val | input | DATA_W (16) | Current value of the watched register |
| op_valid | input | NUM_OPS (3) | One strobe per operation; the operation wrote the register this cycle |
| op_critical | input | NUM_OPS (3) | Per-operation grading: 1 means a mismatch halts, 0 means it warns |
| mismatch_o | output | 1 | One-cycle pulse when any fault is detected |
| warn_o | output | 1 | One-cycle pulse when a non-critical mismatch is detected |
| halt_o | output | 1 | Sticky halt |
| flt_code | output | 3 | Kind of the first fault |
| flt_op | output | OP_W (2) | Operation index of the first fault |
| flt_count | output | CNT_W (3) | Execution index of the first fault |
| flt_expected | output | CMP_W (8) | Expected slice of the first fault |
| flt_actual | output | CMP_W (8) | Observed slice of the first fault |
| flt_cycle | output | CYC_W (16) | Cycle of the first fault |

## Verification
Correct values are first driven in an interleaved order across all three operations, with junk in the unused register bits. Silence here separates per-operation counters from a single shared counter and shows that masking works. A wrong value on a non-critical operation is followed by the correct next entry. This shows whether the position advances on a mismatch and whether a warning leaves the run alive. Separate runs then open with a critical mismatch, an overrun and a same-cycle conflict. Each produces a distinct recorded code, and the post-halt strobes and the frozen record show that later events are ignored.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_WARN     = 3'd1,
        FLT_CRIT     = 3'd2,
        FLT_OVERRUN  = 3'd3,
        FLT_CONFLICT = 3'd4
    } tc_fault_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_WARNED = 2'd1,
        ST_HALTED = 2'd2
    } tc_state_e;

    // number of expected entries for operation op
    function automatic int unsigned tc_len(input int unsigned op, input int unsigned depth);
        return depth - (op % depth);
    endfunction

    // expected slice for execution idx of operation op (caller truncates)
    function automatic logic [31:0] tc_exp(input int unsigned op, input int unsigned idx);
        return 32'((op + 1) * 16 + idx * 3 + 1);
    endfunction

endpackage

// File: rtl/tc_op_counter.sv
module tc_op_counter #(
    parameter int CNT_W = 3,
    parameter int LEN   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LEN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv && cnt < LIMIT) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cnt < LIMIT) |=> (cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/tc_expect_table.sv
module tc_expect_table #(
    parameter int NUM_OPS = 3,
    parameter int DEPTH   = 4,
    parameter int CMP_W   = 8,
    parameter int OP_W    = 2,
    parameter int CNT_W   = 3
) (
    input  logic [OP_W-1:0]  op_sel,
    input  logic [CNT_W-1:0] idx,
    output logic [CMP_W-1:0] expected
);
    import tc_pkg::*;

    logic [CMP_W-1:0] tbl [NUM_OPS][DEPTH];

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            assign tbl[o][e] = CMP_W'(tc_exp(o, e));
        end
    end

    always_comb begin
        expected = '0;
        for (int o = 0; o < NUM_OPS; o++) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (op_sel == OP_W'(o) && idx == CNT_W'(e)) begin
                    expected = tbl[o][e];
                end
            end
        end
    end

endmodule

// File: rtl/tc_fault_fsm.sv
module tc_fault_fsm #(
    parameter int OP_W  = 2,
    parameter int CNT_W = 3,
    parameter int CMP_W = 8,
    parameter int CYC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk,
    input  tc_pkg::tc_fault_e code,
    input  logic [OP_W-1:0]   op,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CMP_W-1:0]  expected,
    input  logic [CMP_W-1:0]  actual,
    input  logic [CYC_W-1:0]  cyc,
    output logic              mismatch_o,
    output logic              warn_o,
    output logic              halt_o,
    output logic [2:0]        rec_code,
    output logic [OP_W-1:0]   rec_op,
    output logic [CNT_W-1:0]  rec_cnt,
    output logic [CMP_W-1:0]  rec_exp,
    output logic [CMP_W-1:0]  rec_act,
    output logic [CYC_W-1:0]  rec_cyc
);
    import tc_pkg::*;

    tc_state_e state, state_nx;
    logic      severe;

    assign severe = chk && (code == FLT_CRIT || code == FLT_OVERRUN || code == FLT_CONFLICT);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (severe)                           state_nx = ST_HALTED;
                else if (chk && code == FLT_WARN)     state_nx = ST_WARNED;
            end
            ST_WARNED: begin
                if (severe)                           state_nx = ST_HALTED;
            end
            ST_HALTED: state_nx = ST_HALTED;
            default:   state_nx = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        halt_o = (state == ST_HALTED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mismatch_o <= 1'b0;
            warn_o     <= 1'b0;
            rec_code   <= '0;
            rec_op     <= '0;
            rec_cnt    <= '0;
            rec_exp    <= '0;
            rec_act    <= '0;
            rec_cyc    <= '0;
        end else begin
            mismatch_o <= chk && (code != FLT_NONE);
            warn_o     <= chk && (code == FLT_WARN);
            if (state == ST_RUN && chk && code != FLT_NONE) begin
                rec_code <= code;
                rec_op   <= op;
                rec_cnt  <= cnt;
                rec_exp  <= expected;
                rec_act  <= actual;
                rec_cyc  <= cyc;
            end
        end
    end

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    // R10
    record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |=> ($stable(rec_code) && $stable(rec_op) && $stable(rec_cnt)
                               && $stable(rec_exp) && $stable(rec_act) && $stable(rec_cyc)));

    // R6
    warn_is_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |-> (mismatch_o && $onehot0({warn_o, halt_o})));

    // R11
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> (!mismatch_o && !warn_o));

endmodule

// File: rtl/trace_checker.sv
module trace_checker #(
    parameter int NUM_OPS = 3,
    parameter int DEPTH   = 4,
    parameter int DATA_W  = 16,
    parameter int CMP_LSB = 4,
    parameter int CMP_W   = 8,
    parameter int CYC_W   = 16,
    localparam int OP_W   = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [NUM_OPS-1:0] op_valid,
    input  logic [NUM_OPS-1:0] op_critical,
    output logic              mismatch_o,
    output logic              warn_o,
    output logic              halt_o,
    output logic [2:0]        flt_code,
    output logic [OP_W-1:0]   flt_op,
    output logic [CNT_W-1:0]  flt_count,
    output logic [CMP_W-1:0]  flt_expected,
    output logic [CMP_W-1:0]  flt_actual,
    output logic [CYC_W-1:0]  flt_cycle
);
    import tc_pkg::*;

    logic [CNT_W-1:0] cnt_a [NUM_OPS];
    logic [NUM_OPS-1:0] adv;
    logic             multi, any_v, chk, sel_crit, overrun;
    logic [OP_W-1:0]  sel_op;
    logic [CNT_W-1:0] sel_cnt, sel_len;
    logic [CMP_W-1:0] actual, tbl_val, exp_rep;
    logic [CYC_W-1:0] cyc;
    tc_fault_e        code;

    assign any_v  = |op_valid;
    assign multi  = (op_valid & (op_valid - NUM_OPS'(1))) != '0;
    assign chk    = any_v && !halt_o;
    assign actual = reg_val[CMP_LSB +: CMP_W];

    always_comb begin
        sel_op   = '0;
        sel_cnt  = '0;
        sel_len  = '0;
        sel_crit = 1'b0;
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            if (op_valid[i]) begin
                sel_op   = OP_W'(i);
                sel_cnt  = cnt_a[i];
                sel_len  = CNT_W'(tc_len(i, DEPTH));
                sel_crit = op_critical[i];
            end
        end
    end

    assign overrun = sel_cnt >= sel_len;

    always_comb begin
        if (multi)                   code = FLT_CONFLICT;
        else if (overrun)            code = FLT_OVERRUN;
        else if (actual != tbl_val)  code = sel_crit ? FLT_CRIT : FLT_WARN;
        else                         code = FLT_NONE;
    end

    assign exp_rep = (code == FLT_OVERRUN || code == FLT_CONFLICT) ? '0 : tbl_val;

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_cnt
        assign adv[k] = op_valid[k] && !halt_o && !multi;
        tc_op_counter #(.CNT_W(CNT_W), .LEN(tc_len(k, DEPTH))) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv[k]),
            .cnt   (cnt_a[k])
        );
    end

    tc_expect_table #(
        .NUM_OPS(NUM_OPS), .DEPTH(DEPTH), .CMP_W(CMP_W), .OP_W(OP_W), .CNT_W(CNT_W)
    ) u_tbl (
        .op_sel   (sel_op),
        .idx      (sel_cnt),
        .expected (tbl_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else        cyc <= cyc + CYC_W'(1);
    end

    tc_fault_fsm #(.OP_W(OP_W), .CNT_W(CNT_W), .CMP_W(CMP_W), .CYC_W(CYC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk        (chk),
        .code       (code),
        .op         (sel_op),
        .cnt        (sel_cnt),
        .expected   (exp_rep),
        .actual     (actual),
        .cyc        (cyc),
        .mismatch_o (mismatch_o),
        .warn_o     (warn_o),
        .halt_o     (halt_o),
        .rec_code   (flt_code),
        .rec_op     (flt_op),
        .rec_cnt    (flt_count),
        .rec_exp    (flt_expected),
        .rec_act    (flt_actual),
        .rec_cyc    (flt_cycle)
    );

    // R9
    conflict_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_o && $countones(op_valid) > 1) |=> (halt_o && mismatch_o));

endmodule

// File: tb/trace_checker_test.sv
`timescale 1ns/1ps
module trace_checker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_val = '0;
    logic [2:0]  op_valid = '0;
    logic [2:0]  op_critical = '0;
    logic        mismatch_o, warn_o, halt_o;
    logic [2:0]  flt_code;
    logic [1:0]  flt_op;
    logic [2:0]  flt_count;
    logic [7:0]  flt_expected, flt_actual;
    logic [15:0] flt_cycle;

    int checks = 0;
    int failures = 0;
    int bcyc = 0;

    always #10 clk = ~clk;

    trace_checker uut (
        .clk(clk), .rst_n(rst_n), .reg_val(reg_val), .op_valid(op_valid),
        .op_critical(op_critical), .mismatch_o(mismatch_o), .warn_o(warn_o),
        .halt_o(halt_o), .flt_code(flt_code), .flt_op(flt_op), .flt_count(flt_count),
        .flt_expected(flt_expected), .flt_actual(flt_actual), .flt_cycle(flt_cycle)
    );

    always @(posedge clk) begin
        if (!rst_n) bcyc <= 0;
        else        bcyc <= bcyc + 1;
    end

    typedef struct {
        logic  mm;
        logic  wn;
        logic  hl;
        string tag;
    } item_t;

    item_t q[$];

    // bench model state
    int   cnt_m[3];
    logic halted_m;
    logic rec_v;
    int   r_code, r_op, r_cnt, r_exp, r_act, r_cyc;

    function automatic logic [7:0] bexp(int op, int i);
        return 8'(16 * (op + 1) + 3 * i + 1);
    endfunction

    function automatic int blen(int op);
        return 4 - op;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 3; i++) cnt_m[i] = 0;
        halted_m = 0; rec_v = 0;
        r_code = 0; r_op = 0; r_cnt = 0; r_exp = 0; r_act = 0; r_cyc = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = '0;
        repeat (2) @(negedge clk);
        model_clear();
        rst_n = 1'b1;
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = '0;
    endtask

    // driver: drives one strobe pattern and pushes the predicted outcome
    task automatic fire(logic [2:0] mask, logic [7:0] val, logic crit, string tag);
        item_t it;
        int code, op, e;
        @(negedge clk);
        reg_val     = {4'(bcyc * 5 + 9), val, 4'(bcyc * 7 + 3)};
        op_valid    = mask;
        op_critical = {3{crit}};
        code = 0; op = 0; e = 0;
        for (int i = 2; i >= 0; i--) if (mask[i]) op = i;
        if (!halted_m) begin
            if ($countones(mask) > 1) begin
                code = 4;
            end else if (cnt_m[op] >= blen(op)) begin
                code = 3;
            end else begin
                e = bexp(op, cnt_m[op]);
                if (val != e[7:0]) code = crit ? 2 : 1;
                cnt_m[op]++;
            end
            if (code >= 3) e = 0;
            if (code != 0 && !rec_v) begin
                rec_v = 1; r_code = code; r_op = op; r_cnt = (code == 4) ? cnt_m[op] : ((code == 3) ? cnt_m[op] : cnt_m[op] - 1);
                r_exp = e; r_act = val; r_cyc = bcyc;
            end
            if (code >= 2) halted_m = 1;
        end
        it.mm = (code != 0);
        it.wn = (code == 1);
        it.hl = halted_m;
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: pops predictions and compares them with the outputs
    always @(posedge clk) begin
        #2;
        if (q.size() != 0) begin
            item_t it;
            it = q.pop_front();
            check(it.tag, "mismatch_o", int'(mismatch_o), int'(it.mm));
            check(it.tag, "warn_o", int'(warn_o), int'(it.wn));
            check(it.tag, "halt_o", int'(halt_o), int'(it.hl));
        end
    end

    task automatic check_rec(string tag);
        check(tag, "flt_code", int'(flt_code), r_code);
        check(tag, "flt_op", int'(flt_op), r_op);
        check(tag, "flt_count", int'(flt_count), r_cnt);
        check(tag, "flt_expected", int'(flt_expected), r_exp);
        check(tag, "flt_actual", int'(flt_actual), r_act);
        check(tag, "flt_cycle", int'(flt_cycle), r_cyc);
    endtask

    initial begin
        model_clear();
        do_reset();
        idle();
        // R1 reset state
        check("R1", "mismatch_o", int'(mismatch_o), 0);
        check("R1", "warn_o", int'(warn_o), 0);
        check("R1", "halt_o", int'(halt_o), 0);
        check_rec("R1");

        // R3 R4 R2: interleaved correct values, junk outside the slice
        fire(3'b001, 8'h11, 1'b1, "R3");
        fire(3'b010, 8'h21, 1'b1, "R4");
        fire(3'b001, 8'h14, 1'b1, "R4");
        fire(3'b100, 8'h31, 1'b1, "R2");
        fire(3'b010, 8'h24, 1'b1, "R4");
        // R6 non-critical mismatch on op0 entry 2
        fire(3'b001, 8'h99, 1'b0, "R6");
        idle();
        check_rec("R10");
        // R5 position advanced past the mismatch: entry 3 is 0x1A
        fire(3'b001, 8'h1A, 1'b1, "R5");
        // R8 overrun of op0; record keeps the warning (R10)
        fire(3'b001, 8'h1A, 1'b1, "R8");
        idle();
        check_rec("R10");
        repeat (3) idle();
        check("R7", "halt_o sticky", int'(halt_o), 1);

        // R7 critical mismatch first, then R11 strobe while halted
        do_reset();
        fire(3'b100, 8'h55, 1'b1, "R7");
        fire(3'b010, 8'h00, 1'b1, "R11");
        idle();
        check_rec("R7");

        // R9 conflict
        do_reset();
        fire(3'b011, 8'h11, 1'b1, "R9");
        idle();
        check_rec("R9");

        // R8 overrun as first fault on op2 (two entries)
        do_reset();
        fire(3'b100, 8'h31, 1'b0, "R3");
        fire(3'b100, 8'h34, 1'b0, "R3");
        fire(3'b100, 8'h34, 1'b0, "R8");
        idle();
        check_rec("R8");
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule